// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-clock static memory with registered address and control. Each access is decoded at the clock edge where its address is taken. A write takes its data one edge later. A read loads the output register one edge later. A two-bit burst counter steps the low address bits, either linearly or in interleaved order. A burst begins on one of two address strobes and moves forward on an advance input. The processor-side strobe always starts a read. The controller-side strobe starts either a read or a write.

The word is split into byte lanes. Each lane holds eight data bits and one parity bit. Writes come either from a global write input that covers every lane, or from a byte-write enable qualified by a select for each lane. The shared data bus is modelled as separate `din`, `dout` and `dout_en` ports.

Output enable acts without the clock. The bus is released during a write data phase. After a deselect, the outputs stay on for one more clock. A sleep input idles the block and releases the bus. After sleep ends, accesses are refused for a set number of clocks.

Top module: `burst_sram`

## Requirements
- R1: Synchronous reset clears `dout` to zero, drives `dout_en` low and ends any burst, so that continue cycles issued after reset produce no output.
- R2: When `wr_all_n` is low in the cycle a strobe loads the address, every lane is written with the `din` present at the following clock. Lane i occupies bits [9i+8:9i].
- R3: When `wr_all_n` is high and `wr_lane_en_n` is low, only the lanes whose `lane_sel_n` bit is low are written, and the other lanes keep their contents. If no lane is selected, nothing is written.
- R4: The device is selected only when `sel0_n` is low, `sel1` is high and `sel2_n` is low. A strobe taken while the device is not selected is a deselect and ends the burst. `proc_req_n` is ignored while `sel0_n` is high, and the cycle is then decoded as if that strobe were absent.
- R5: `proc_req_n` has priority over `ctl_req_n` and always starts a read. Write enables present in that cycle are ignored.
- R6: The output register loads the read word at the clock after the clock that registered the read address. `dout_en` is low between those two clocks if the outputs were off before.
- R7: With `ilv_order` high, the n-th burst address has low bits equal to the start value XOR n. With `ilv_order` low, the low bits are the start value plus n, modulo 4. The upper address bits never change during a burst.
- R8: A continue cycle with `adv_n` high repeats the current burst address. With `adv_n` low, it moves to the next address.
- R9: `out_en_n` gates `dout_en` combinationally, without waiting for a clock edge.
- R10: During the data phase of a write, `dout_en` is low whatever `out_en_n` is. After the write, it stays low until a read loads new data.
- R11: After a deselect is registered, the outputs keep driving the last word through the next clock and are released at the second clock.
- R12: While `sleep` is high, `dout_en` is low and every access is ignored.
- R13: After `sleep` falls, the first two clocks ignore accesses and the third clock accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, taken on a strobe |
| sel0_n | input | 1 | Chip select 0, active low; also qualifies `proc_req_n` |
| sel1 | input | 1 | Chip select 1, active high |
| sel2_n | input | 1 | Chip select 2, active low |
| proc_req_n | input | 1 | Processor-side address strobe, active low |
| ctl_req_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Lane selects for byte writes, active low |
| ilv_order | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Output register contents |
| dout_en | output | 1 | Bus drive enable for `dout` |

## Verification
Write data is due one clock after the address clock, and read data one clock after the read address is registered. The bench therefore drives each stimulus just after a falling edge and samples at the falling edge that follows the clock where the result is due. For burst reads, the word for each address is compared one edge after the next address is issued. Deselect release is checked at the falling edges after the first and the second clocks, and wake-up is tested with a write attempt on the last refused clock. Output-enable and sleep gating are sampled one time unit after the input changes, with no clock edge in between.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2,
      OP_DSL  = 2'd3
   } op_e;

   // low two address bits of a burst step
   function automatic logic [1:0] burst_low(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
      logic [1:0] r;
      r = ilv ? (base ^ cnt) : (base + cnt);
      return r;
   endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
   import bsram_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int LANES    = 4,
   parameter int WAKE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              proc_req_n,
   input  logic              ctl_req_n,
   input  logic              adv_n,
   input  logic              wr_all_n,
   input  logic              wr_lane_en_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              ilv_order,
   input  logic              sleep,
   output op_e               acc_op,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [LANES-1:0]  acc_lanes
);
   localparam int CW = $clog2(WAKE_CYC + 1);

   logic              all_sel, p_take, c_take, blocked, cont_now;
   logic [LANES-1:0]  wr_mask;
   logic [ADDR_W-1:0] base_q, nxt_addr;
   logic [1:0]        cnt_q, cnt_nxt;
   logic              active_q, start, kill;
   logic [CW-1:0]     wake_q;
   op_e               nxt_op, op_q;
   logic [LANES-1:0]  nxt_lanes;

   assign all_sel  = !sel0_n && sel1 && !sel2_n;
   assign wr_mask  = !wr_all_n ? {LANES{1'b1}} :
                     (!wr_lane_en_n ? ~lane_sel_n : {LANES{1'b0}});
   assign p_take   = !proc_req_n && !sel0_n;
   assign c_take   = !p_take && !ctl_req_n;
   assign blocked  = sleep || (wake_q != '0);
   assign cont_now = !blocked && !p_take && !c_take;

   always_comb begin
      nxt_op    = OP_NONE;
      nxt_addr  = acc_addr;
      nxt_lanes = '0;
      cnt_nxt   = cnt_q;
      start     = 1'b0;
      kill      = 1'b0;
      if (blocked) begin
         kill = 1'b1;
      end else if (p_take || c_take) begin
         if (!all_sel) begin
            nxt_op = OP_DSL;
            kill   = 1'b1;
         end else begin
            start    = 1'b1;
            nxt_addr = addr;
            cnt_nxt  = 2'd0;
            if (c_take && (wr_mask != '0)) begin
               nxt_op    = OP_WR;
               nxt_lanes = wr_mask;
            end else begin
               nxt_op = OP_RD;
            end
         end
      end else if (active_q) begin
         if (!adv_n) cnt_nxt = cnt_q + 2'd1;
         nxt_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nxt, ilv_order)};
         if (wr_mask != '0) begin
            nxt_op    = OP_WR;
            nxt_lanes = wr_mask;
         end else begin
            nxt_op = OP_RD;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q      <= OP_NONE;
         acc_addr  <= '0;
         acc_lanes <= '0;
         base_q    <= '0;
         cnt_q     <= '0;
         active_q  <= 1'b0;
         wake_q    <= '0;
      end else begin
         op_q      <= nxt_op;
         acc_addr  <= nxt_addr;
         acc_lanes <= nxt_lanes;
         cnt_q     <= cnt_nxt;
         if (start) begin
            base_q   <= addr;
            active_q <= 1'b1;
         end else if (kill) begin
            active_q <= 1'b0;
         end
         if (sleep)
            wake_q <= CW'(WAKE_CYC);
         else if (wake_q != '0)
            wake_q <= wake_q - 1'b1;
      end
   end

   assign acc_op = op_q;

   assert_write_has_lane_R3: assert property (@(posedge clk) disable iff (rst)
      (op_q == OP_WR) |-> (acc_lanes != '0));

   assert_burst_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
      (active_q && (op_q == OP_RD || op_q == OP_WR) && cont_now)
      |=> $stable(acc_addr[ADDR_W-1:2]));

   assert_sleep_ignores_R12: assert property (@(posedge clk) disable iff (rst)
      sleep |=> (op_q == OP_NONE));

   assert_wake_ignores_R13: assert property (@(posedge clk) disable iff (rst)
      (wake_q != '0) |=> (op_q == OP_NONE));

endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
   parameter int ADDR_W = 4,
   parameter int W      = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/bsram_out.sv
module bsram_out
   import bsram_pkg::*;
#(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst,
   input  op_e           op,
   input  logic [DW-1:0] rdata,
   input  logic          sleep,
   input  logic          out_en_n,
   output logic [DW-1:0] dout,
   output logic          dout_en,
   output logic          drive
);
   logic [DW-1:0] dout_q;
   logic          drv_q, dsl2_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_q <= '0;
         drv_q  <= 1'b0;
         dsl2_q <= 1'b0;
      end else begin
         dsl2_q <= (op == OP_DSL);
         if (sleep) begin
            drv_q <= 1'b0;
         end else if (op == OP_RD) begin
            dout_q <= rdata;
            drv_q  <= 1'b1;
         end else if (op == OP_WR || dsl2_q) begin
            drv_q <= 1'b0;
         end
      end
   end

   assign dout    = dout_q;
   assign drive   = drv_q;
   assign dout_en = !out_en_n && drv_q && (op != OP_WR) && !sleep;

   assert_dcd_release_R11: assert property (@(posedge clk) disable iff (rst)
      (dsl2_q && op != OP_RD) |=> !drv_q);

   assert_sleep_drop_R12: assert property (@(posedge clk) disable iff (rst)
      sleep |=> !drv_q);

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import bsram_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int LANES    = 4,
   parameter int LANE_W   = 9,
   parameter int WAKE_CYC = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    sel0_n,
   input  logic                    sel1,
   input  logic                    sel2_n,
   input  logic                    proc_req_n,
   input  logic                    ctl_req_n,
   input  logic                    adv_n,
   input  logic                    wr_all_n,
   input  logic                    wr_lane_en_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    ilv_order,
   input  logic                    out_en_n,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int DW = LANES * LANE_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("burst_sram: ADDR_W must be at least 2");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram: LANES and LANE_W must be positive");
   end
   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("burst_sram: WAKE_CYC must be positive");
   end

   op_e               acc_op;
   logic [ADDR_W-1:0] acc_addr;
   logic [LANES-1:0]  acc_lanes;
   logic [DW-1:0]     rdata;
   logic              drive;

   bsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_ctrl (
      .clk(clk), .rst(rst), .addr(addr),
      .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .proc_req_n(proc_req_n), .ctl_req_n(ctl_req_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
      .ilv_order(ilv_order), .sleep(sleep),
      .acc_op(acc_op), .acc_addr(acc_addr), .acc_lanes(acc_lanes)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      bsram_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
         .clk(clk),
         .we((acc_op == OP_WR) && acc_lanes[g]),
         .addr(acc_addr),
         .wdata(din[g*LANE_W +: LANE_W]),
         .rdata(rdata[g*LANE_W +: LANE_W])
      );
   end

   bsram_out #(.DW(DW)) u_out (
      .clk(clk), .rst(rst), .op(acc_op), .rdata(rdata),
      .sleep(sleep), .out_en_n(out_en_n),
      .dout(dout), .dout_en(dout_en), .drive(drive)
   );

   assert_read_drives_R6: assert property (@(posedge clk) disable iff (rst)
      (acc_op == OP_RD && !sleep) |=> drive);

   assert_write_releases_R10: assert property (@(posedge clk) disable iff (rst)
      (acc_op == OP_WR && !sleep) |=> !drive);

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic [3:0]  addr;
   logic        sel0_n, sel1, sel2_n, proc_req_n, ctl_req_n, adv_n;
   logic        wr_all_n, wr_lane_en_n, ilv_order, out_en_n, sleep;
   logic [3:0]  lane_sel_n;
   logic [35:0] din, dout;
   logic        dout_en;

   logic [35:0] model_mem [16];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_sram u_dut (
      .clk(clk), .rst(rst), .addr(addr),
      .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .proc_req_n(proc_req_n), .ctl_req_n(ctl_req_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
      .ilv_order(ilv_order), .out_en_n(out_en_n), .sleep(sleep),
      .din(din), .dout(dout), .dout_en(dout_en)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_en(input string req, input logic exp);
      chk(req, {35'd0, dout_en}, {35'd0, exp});
   endtask

   function automatic logic [35:0] pat(input int a);
      return 36'h9_1234_5670 ^ (36'(a) * 36'h1_0101_0101);
   endfunction

   function automatic logic [3:0] baddr(input logic [3:0] s, input int i, input bit ilv);
      logic [1:0] c;
      c = 2'(i);
      return {s[3:2], ilv ? (s[1:0] ^ c) : (s[1:0] + c)};
   endfunction

   task automatic idle();
      sel0_n = 0; sel1 = 1; sel2_n = 0;
      proc_req_n = 1; ctl_req_n = 1; adv_n = 1;
      wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = 4'hF;
      ilv_order = 0; out_en_n = 0; sleep = 0;
   endtask

   // deselect via controller strobe with sel0_n off, then let outputs release
   task automatic quiesce();
      idle(); ctl_req_n = 0; sel0_n = 1; step();
      idle(); step(); step();
   endtask

   task automatic do_write(input logic [3:0] a, input logic [35:0] d,
                           input bit all, input logic [3:0] lanes_n);
      idle(); addr = a; ctl_req_n = 0;
      if (all) wr_all_n = 0; else begin wr_lane_en_n = 0; lane_sel_n = lanes_n; end
      step();
      idle(); ctl_req_n = 0; sel0_n = 1; din = d;
      step();
      for (int l = 0; l < 4; l++)
         if (all || !lanes_n[l]) model_mem[a][l*9 +: 9] = d[l*9 +: 9];
      idle(); step(); step();
   endtask

   task automatic read_burst(input logic [3:0] s, input bit ilv, input int n, input string tag);
      logic [3:0] a_prev;
      a_prev = s;
      idle(); ilv_order = ilv;
      for (int i = 0; i < n; i++) begin
         if (i == 0) begin proc_req_n = 0; addr = s; end
         else begin proc_req_n = 1; adv_n = 0; end
         step();
         if (i > 0) begin chk(tag, dout, model_mem[a_prev]); chk_en(tag, 1'b1); end
         a_prev = baddr(s, i, ilv);
      end
      proc_req_n = 1; adv_n = 1; ctl_req_n = 0; sel0_n = 1;
      step();
      chk(tag, dout, model_mem[a_prev]);
      idle(); step(); step();
   endtask

   task automatic t_reset();
      idle(); rst = 1; addr = 0; din = '0;
      step(); step(); rst = 0;
      chk("R1 reset dout", dout, 36'd0);
      chk_en("R1 reset enable", 1'b0);
      adv_n = 0; step(); step();
      chk_en("R1 no burst after reset", 1'b0);
      idle(); step();
   endtask

   task automatic t_global_write();
      for (int a = 0; a < 16; a++) do_write(4'(a), pat(a), 1'b1, 4'hF);
      for (int b = 0; b < 16; b += 4) read_burst(4'(b), 1'b0, 4, "R2 global write");
   endtask

   task automatic t_byte_write();
      do_write(4'd5, 36'hA_BCDE_F012, 1'b0, 4'b1010);
      read_burst(4'd5, 1'b0, 1, "R3 lanes 0,2 written");
      do_write(4'd6, 36'h0_FFFF_FFFF, 1'b0, 4'b1111);
      read_burst(4'd6, 1'b0, 1, "R3 no lane selected");
   endtask

   task automatic t_order();
      read_burst(4'd9, 1'b0, 4, "R7 linear from 9");
      read_burst(4'd9, 1'b1, 4, "R7 interleaved from 9");
      read_burst(4'd14, 1'b1, 4, "R7 interleaved from 14");
   endtask

   task automatic t_suspend();
      idle(); proc_req_n = 0; addr = 6; step();
      idle(); adv_n = 1; step();
      chk("R8 first word", dout, model_mem[6]);
      adv_n = 0; step();
      chk("R8 suspended word", dout, model_mem[6]);
      adv_n = 1; ctl_req_n = 0; sel0_n = 1; step();
      chk("R8 advanced word", dout, model_mem[7]);
      idle(); step(); step();
   endtask

   task automatic t_select();
      idle(); proc_req_n = 0; addr = 2; step();
      idle(); proc_req_n = 0; sel0_n = 1; addr = 13; step();
      chk("R4 start word", dout, model_mem[2]);
      idle(); ctl_req_n = 0; sel1 = 0; step();
      chk("R4 ignored strobe keeps address", dout, model_mem[2]);
      idle(); step(); step();
      chk_en("R4 deselect via sel1 releases", 1'b0);
   endtask

   task automatic t_proc_write();
      idle(); proc_req_n = 0; wr_all_n = 0; addr = 3; step();
      idle(); din = 36'h5_5555_5555; step();
      chk("R5 read despite write enable", dout, model_mem[3]);
      quiesce();
      read_burst(4'd3, 1'b0, 1, "R5 memory unchanged");
   endtask

   task automatic t_latency_oe();
      idle(); proc_req_n = 0; addr = 4; step();
      chk_en("R6 not driven before data clock", 1'b0);
      idle(); ctl_req_n = 0; sel0_n = 1; step();
      chk_en("R6 driven at data clock", 1'b1);
      chk("R6 data", dout, model_mem[4]);
      idle(); out_en_n = 1; #1;
      chk_en("R9 oe off without clock", 1'b0);
      out_en_n = 0; #1;
      chk_en("R9 oe on without clock", 1'b1);
      step(); step();
   endtask

   task automatic t_write_hiz();
      idle(); proc_req_n = 0; addr = 1; step();
      idle(); ctl_req_n = 0; wr_all_n = 0; addr = 1; step();
      chk_en("R10 released during write data phase", 1'b0);
      idle(); ctl_req_n = 0; sel0_n = 1; din = 36'h3_3CC3_3CC3; step();
      model_mem[1] = 36'h3_3CC3_3CC3;
      chk_en("R10 stays off after write", 1'b0);
      idle(); step();
      chk_en("R10 still off", 1'b0);
      read_burst(4'd1, 1'b0, 1, "R10 written word");
   endtask

   task automatic t_dcd();
      idle(); proc_req_n = 0; addr = 7; step();
      idle(); ctl_req_n = 0; sel1 = 0; step();
      chk_en("R11 driven when deselect taken", 1'b1);
      idle(); step();
      chk_en("R11 driven after first clock", 1'b1);
      chk("R11 data held", dout, model_mem[7]);
      step();
      chk_en("R11 released after second clock", 1'b0);
   endtask

   task automatic t_sleep();
      idle(); proc_req_n = 0; addr = 0; step();
      idle(); ctl_req_n = 0; sel0_n = 1; step();
      idle(); sleep = 1; #1;
      chk_en("R12 sleep releases bus", 1'b0);
      ctl_req_n = 0; wr_all_n = 0; addr = 0; din = 36'hF_0000_000F;
      step(); step(); step();
      chk_en("R12 off during sleep", 1'b0);
      sleep = 0; step(); step();
      wr_all_n = 1; ctl_req_n = 1; proc_req_n = 0; step();
      proc_req_n = 1; ctl_req_n = 0; sel0_n = 1; step();
      chk("R13 refused writes, read accepted", dout, model_mem[0]);
      chk_en("R13 read accepted on third clock", 1'b1);
      idle(); step(); step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(); rst = 1; addr = 0; din = '0;
      for (int a = 0; a < 16; a++) model_mem[a] = '0;
      step();
      t_reset();
      t_global_write();
      t_byte_write();
      t_order();
      t_suspend();
      t_select();
      t_proc_write();
      t_latency_oe();
      t_write_hiz();
      t_dcd();
      t_sleep();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule